// File: doc/BRIEF.md
# Timer with Buffered Reload Registers

This block is a 16-bit timer counter with three programmable values: a start value, a modulo (period end) value and one channel compare value. Each value has a buffer that software writes and an active copy that the counter and the compare logic use. A load policy decides when the active copy takes the buffered value. The policy looks at four things: whether the counter clock is selected, an enhanced-features enable, the center-aligned mode bit, and a single-cycle synchronization strobe.

While the counter is stopped, writes take effect at once. While it runs, a new period or compare value waits for a counter boundary that depends on the mode. With the enhanced features on, it waits for an explicit synchronization strobe. This keeps the active period consistent within a cycle of the waveform. The start value has its own sync-enable bit. When that bit is clear, the start value loads one clock after it is written.

Top module: `timer_reload`

## Requirements
- R1: After reset the counter, all three active values, all buffers and all pending flags are zero.
- R2: When `clk_sel` is 2'b00 the counter holds its value. A write with `wr_sel` 0 (start), 1 (modulo) or 2 (compare) sets that active value to `wr_data` at the same clock edge, whatever `enh_en` is.
- R3: When `clk_sel` is 2'b00, a value still pending from a write made while running is copied to its active register at the next clock edge.
- R4: When running with `center_mode` 0, the counter adds one per clock. At the edge where it equals the active modulo value, it loads the active start value instead. With start 0 and modulo 0xFFFF this is a free-running count that wraps from 0xFFFF to 0x0000.
- R5: When running with `center_mode` 1, the counter counts up to the active modulo value and then steps down by one per clock. On reaching the active start value it counts up again.
- R6: When running and not start-gated, a written start value becomes active at the clock edge after the edge that accepted the write. Start-gated means `enh_en`, `sync_mode` and `start_sync_en` are all 1.
- R7: When running and start-gated, the active start value changes only at an edge where `sync_pulse` is 1 and a start write is pending.
- R8: When running with `enh_en` 0 and `center_mode` 0, a pending modulo or compare value loads at the edge where the counter equals the old active modulo value and rolls over to the start value.
- R9: When running with `enh_en` 0 and `center_mode` 1, a pending modulo or compare value loads at the edge where the counter, counting up, equals the old active modulo value and steps to that value minus one.
- R10: When running with `enh_en` 1, modulo and compare values load only at an edge with `sync_pulse` 1 and a pending write.
- R11: A second write before the load replaces the buffered value. A write at the same edge as a load keeps the load pending with the new value.
- R12: A write with `wr_sel` 3 changes no output and no buffered value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 start, 1 modulo, 2 compare, 3 unused |
| wr_data | input | 16 | Write data |
| clk_sel | input | 2 | Counter clock select, 00 stops the counter |
| enh_en | input | 1 | Enhanced-features enable |
| sync_mode | input | 1 | Synchronization mode select |
| center_mode | input | 1 | Center-aligned (up/down) counting |
| start_sync_en | input | 1 | Start value loads only by synchronization |
| sync_pulse | input | 1 | Single-cycle synchronization strobe |
| count | output | 16 | Counter value |
| start_val | output | 16 | Active start value |
| mod_val | output | 16 | Active modulo value |
| cmp_val | output | 16 | Active compare value |

## Verification
The assertions assume that the active modulo value is above the active start value plus one whenever center-aligned counting runs, so the turn-around points are distinct. They also assume that `sync_pulse` is high for only one cycle per event. The stimulus programs every period while the counter is stopped, or loads a new one at a boundary that keeps this ordering. It drives the strobe through a task that raises it for exactly one clock. Mode bits change only between scenarios, and the reference model in the bench follows each change cycle by cycle.

// File: rtl/timer_reload.sv
module timer_reload #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   clk_sel,
  input  logic         enh_en,
  input  logic         sync_mode,
  input  logic         center_mode,
  input  logic         start_sync_en,
  input  logic         sync_pulse,
  output logic [W-1:0] count,
  output logic [W-1:0] start_val,
  output logic [W-1:0] mod_val,
  output logic [W-1:0] cmp_val
);

  localparam logic [1:0] SEL_START = 2'd0;
  localparam logic [1:0] SEL_MOD   = 2'd1;
  localparam logic [1:0] SEL_CMP   = 2'd2;

  logic [W-1:0] b_start, b_mod, b_cmp;
  logic         p_start, p_mod, p_cmp;
  logic         up;
  logic [W-1:0] cnt_nx;
  logic         up_nx;

  wire running    = clk_sel != 2'b00;
  wire at_mod     = count == mod_val;
  wire edge_hit   = running && at_mod && (!center_mode || up);
  wire start_gate = enh_en && sync_mode && start_sync_en;

  wire wr_s = wr_en && wr_sel == SEL_START;
  wire wr_m = wr_en && wr_sel == SEL_MOD;
  wire wr_c = wr_en && wr_sel == SEL_CMP;

  wire ld_pm    = !running || (enh_en ? sync_pulse : edge_hit);
  wire ld_start = p_start && (!running || !start_gate || sync_pulse);
  wire ld_mod   = p_mod && ld_pm;
  wire ld_cmp   = p_cmp && ld_pm;

  always_comb begin
    cnt_nx = count;
    up_nx  = up;
    if (running) begin
      if (!center_mode) begin
        up_nx  = 1'b1;
        cnt_nx = at_mod ? start_val : count + 1'b1;
      end else if (up) begin
        if (at_mod) begin
          cnt_nx = count - 1'b1;
          up_nx  = 1'b0;
        end else begin
          cnt_nx = count + 1'b1;
        end
      end else if (count == start_val) begin
        cnt_nx = count + 1'b1;
        up_nx  = 1'b1;
      end else begin
        cnt_nx = count - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      up    <= 1'b1;
    end else begin
      count <= cnt_nx;
      up    <= up_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_val <= '0;
      b_start   <= '0;
      p_start   <= 1'b0;
    end else begin
      if (ld_start) start_val <= b_start;
      if (wr_s) begin
        b_start <= wr_data;
        if (!running) start_val <= wr_data;
      end
      p_start <= wr_s ? running : (ld_start ? 1'b0 : p_start);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mod_val <= '0;
      b_mod   <= '0;
      p_mod   <= 1'b0;
    end else begin
      if (ld_mod) mod_val <= b_mod;
      if (wr_m) begin
        b_mod <= wr_data;
        if (!running) mod_val <= wr_data;
      end
      p_mod <= wr_m ? running : (ld_mod ? 1'b0 : p_mod);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_val <= '0;
      b_cmp   <= '0;
      p_cmp   <= 1'b0;
    end else begin
      if (ld_cmp) cmp_val <= b_cmp;
      if (wr_c) begin
        b_cmp <= wr_data;
        if (!running) cmp_val <= wr_data;
      end
      p_cmp <= wr_c ? running : (ld_cmp ? 1'b0 : p_cmp);
    end
  end

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> $stable(count)); // R2
  AST_STOP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && wr_m) |=> mod_val == $past(wr_data)); // R2
  AST_STOP_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !wr_en) |=> (mod_val == $past(b_mod) && start_val == $past(b_start) && cmp_val == $past(b_cmp))); // R3
  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !center_mode && at_mod) |=> count == $past(start_val)); // R4
  AST_CTR_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (running && center_mode && up && at_mod) |=> count == W'($past(count) - 1'b1)); // R5
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start_gate && !sync_pulse) |=> $stable(start_val)); // R7
  AST_BND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !enh_en && !edge_hit) |=> ($stable(mod_val) && $stable(cmp_val))); // R8
  AST_ENH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && enh_en && !sync_pulse) |=> ($stable(mod_val) && $stable(cmp_val))); // R10

endmodule

// File: tb/timer_reload_test.sv
module timer_reload_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  clk_sel = 2'd0;
  logic        enh_en = 1'b0, sync_mode = 1'b0, center_mode = 1'b0;
  logic        start_sync_en = 1'b0, sync_pulse = 1'b0;
  logic [15:0] count, start_val, mod_val, cmp_val;

  timer_reload uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .clk_sel(clk_sel), .enh_en(enh_en), .sync_mode(sync_mode), .center_mode(center_mode),
    .start_sync_en(start_sync_en), .sync_pulse(sync_pulse),
    .count(count), .start_val(start_val), .mod_val(mod_val), .cmp_val(cmp_val)
  );

  always #5 clk = ~clk;

  int m_cnt, m_st, m_md, m_cp, bf_st, bf_md, bf_cp;
  bit pd_st, pd_md, pd_cp, m_up;
  int nvec = 0, nfail = 0;
  string cur_req = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_st = 0; m_md = 0; m_cp = 0;
      bf_st = 0; bf_md = 0; bf_cp = 0;
      pd_st = 0; pd_md = 0; pd_cp = 0; m_up = 1;
    end else begin
      bit run, bnd, gate, lpm;
      int oc;
      run  = clk_sel != 0;
      oc   = m_cnt;
      bnd  = run && (oc == m_md) && (!center_mode || m_up);
      gate = enh_en && sync_mode && start_sync_en;
      if (run) begin
        if (!center_mode) begin
          m_up = 1;
          m_cnt = (oc == m_md) ? m_st : (oc + 1) & 16'hFFFF;
        end else if (m_up) begin
          if (oc == m_md) begin m_cnt = (oc - 1) & 16'hFFFF; m_up = 0; end
          else m_cnt = (oc + 1) & 16'hFFFF;
        end else if (oc == m_st) begin
          m_cnt = (oc + 1) & 16'hFFFF; m_up = 1;
        end else m_cnt = (oc - 1) & 16'hFFFF;
      end
      lpm = !run || (enh_en ? sync_pulse : bnd);
      if (pd_st && (!run || !gate || sync_pulse)) begin m_st = bf_st; pd_st = 0; end
      if (pd_md && lpm) begin m_md = bf_md; pd_md = 0; end
      if (pd_cp && lpm) begin m_cp = bf_cp; pd_cp = 0; end
      if (wr_en) begin
        case (wr_sel)
          2'd0: begin bf_st = wr_data; if (!run) m_st = wr_data; pd_st = run; end
          2'd1: begin bf_md = wr_data; if (!run) m_md = wr_data; pd_md = run; end
          2'd2: begin bf_cp = wr_data; if (!run) m_cp = wr_data; pd_cp = run; end
          default: ;
        endcase
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
    nvec++;
    if (count !== 16'(m_cnt) || start_val !== 16'(m_st) || mod_val !== 16'(m_md) || cmp_val !== 16'(m_cp)) begin
      nfail++;
      $display("FAIL %s: cnt/start/mod/cmp actual %h/%h/%h/%h expected %h/%h/%h/%h", cur_req,
               count, start_val, mod_val, cmp_val, 16'(m_cnt), 16'(m_st), 16'(m_md), 16'(m_cp));
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pulse();
    sync_pulse = 1'b1;
    tick();
    sync_pulse = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    #(190000 * 10);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    run(2);
    rst_n = 1'b1;
    run(2);
    cur_req = "R2";
    wr(2'd0, 16'd2);
    enh_en = 1'b1;
    wr(2'd1, 16'd9);
    wr(2'd2, 16'd5);
    enh_en = 1'b0;
    run(2);
    cur_req = "R12";
    wr(2'd3, 16'h7777);
    run(2);
    cur_req = "R4";
    clk_sel = 2'd1;
    run(25);
    cur_req = "R8";
    wr(2'd1, 16'd6);
    run(3);
    wr(2'd2, 16'd3);
    run(15);
    cur_req = "R6";
    wr(2'd0, 16'd1);
    run(12);
    cur_req = "R7";
    enh_en = 1'b1; sync_mode = 1'b1; start_sync_en = 1'b1;
    wr(2'd0, 16'd3);
    run(9);
    pulse();
    run(5);
    cur_req = "R10";
    wr(2'd1, 16'd12);
    wr(2'd2, 16'd8);
    run(20);
    pulse();
    run(20);
    cur_req = "R11";
    wr(2'd1, 16'd14);
    run(2);
    wr(2'd1, 16'd11);
    run(3);
    pulse();
    run(12);
    start_sync_en = 1'b0;
    enh_en = 1'b0;
    wr(2'd1, 16'd8);
    run(2);
    wait (count == 16'd10);
    #1;
    wr(2'd1, 16'd9);
    run(25);
    cur_req = "R5";
    center_mode = 1'b1;
    run(40);
    cur_req = "R9";
    wr(2'd1, 16'd13);
    wr(2'd2, 16'd4);
    run(40);
    cur_req = "R3";
    enh_en = 1'b1;
    wr(2'd1, 16'd20);
    wr(2'd0, 16'd2);
    run(3);
    clk_sel = 2'd0;
    run(4);
    enh_en = 1'b0; sync_mode = 1'b0; center_mode = 1'b0;
    cur_req = "R4";
    wr(2'd0, 16'd0);
    wr(2'd1, 16'hFFFF);
    clk_sel = 2'd2;
    run(65560);
    finish_run();
  end
endmodule